// File: doc/BRIEF.md
# Return Address Stack Predictor

This block is a small return-address stack for the front end of a pipelined, in-order processor. When the front end reports a call, the block pushes the return address onto a four-entry circular stack. It also looks at the fields of each decoded instruction. One exact load pattern counts as a procedure return: a single-register load into the PC, based on the stack pointer R13, post-indexed, with an immediate offset of plus four. When that pattern appears, the block pops the top entry and presents it as the predicted return target in the next cycle.

The prediction does not depend on the instruction's condition field. A conditional return whose condition outcome was guessed wrongly elsewhere still gets its target from the stack. The front end can read a checkpoint of the stack pointer and the occupancy. On a flush it hands that checkpoint back to roll the stack back. The stored entries are never erased. Only the pointer and the count are restored.

Top module: `ras_predictor`

## Requirements
- R1: While reset is held and after it is released, `pred_valid_o` is 0, `ckpt_ptr_o` is 0 and `ckpt_cnt_o` is 0.
- R2: A return is decoded only when all of these hold: `dec_valid_i`=1, `dec_single_load_i`=1, `dec_rd_i`=15, `dec_rn_i`=13, `dec_post_idx_i`=1, `dec_imm_i`=1, `dec_up_i`=1 and `dec_offset_i`=4. Any other combination neither pops nor predicts.
- R3: `push_i` stores `push_addr_i` at the top of the stack. Returns pop the entries in last-in, first-out order. `pred_valid_o` and `pred_target_o` appear one cycle after the return is presented.
- R4: The stack holds 4 entries. A push onto a full stack overwrites the oldest entry, so after five pushes the pops yield the last four addresses, newest first.
- R5: A return seen while the stack is empty gives `pred_valid_o`=0 in the next cycle and leaves the pointer and the count unchanged.
- R6: When a push and a return arrive in the same cycle, the push takes effect, no pop happens and `pred_valid_o` is 0 in the next cycle.
- R7: `flush_i` loads `flush_ptr_i` into the pointer and `flush_cnt_i` into the count. It overrides any push or return in that cycle and gives `pred_valid_o`=0 in the next cycle.
- R8: `pred_target_o` bit 0 is always 0. The remaining bits are the stored address.
- R9: The value of `dec_cond_i` has no effect on return detection or on the target.
- R10: `ckpt_ptr_o` is the index of the next slot to write, which wraps modulo 4. `ckpt_cnt_o` is the number of valid entries, from 0 to 4, and saturates at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Call seen: push the return address |
| push_addr_i | input | 32 | Return address to push |
| dec_valid_i | input | 1 | Decoded instruction bundle valid |
| dec_single_load_i | input | 1 | Instruction is a single-register load |
| dec_rd_i | input | 4 | Destination register index |
| dec_rn_i | input | 4 | Base register index |
| dec_post_idx_i | input | 1 | Post-indexed addressing |
| dec_imm_i | input | 1 | Offset is an immediate |
| dec_up_i | input | 1 | Offset is added (1) or subtracted (0) |
| dec_offset_i | input | 12 | Immediate offset magnitude |
| dec_cond_i | input | 4 | Condition field (ignored) |
| flush_i | input | 1 | Restore the stack state from the checkpoint |
| flush_ptr_i | input | 2 | Checkpointed pointer |
| flush_cnt_i | input | 3 | Checkpointed count |
| pred_valid_o | output | 1 | Predicted return target valid |
| pred_target_o | output | 32 | Predicted return target, bit 0 clear |
| ckpt_ptr_o | output | 2 | Current pointer, for checkpointing |
| ckpt_cnt_o | output | 3 | Current count, for checkpointing |

## Verification
The bench changes each field of the return pattern one at a time. A decoder that checked too few fields would pop on a near miss. That shows up as a spurious prediction and as a wrong target on the next real return. It also pushes five addresses and pops past the bottom. A stack that failed to wrap, or failed to cap its count, would return a stale fifth target or a non-empty result. A push and a return in the same cycle, a flush that arrives together with both, and an odd stored address are each checked. A design with the wrong priority, a flush that restored only part of the state, or an unmasked bit 0 would give a visible prediction or a visible target that differs from the expected one.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned ADDR_W = 32;

  typedef struct packed {
    logic             valid;
    logic             single_load;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rn;
    logic             post_idx;
    logic             imm;
    logic             up;
    logic [OFF_W-1:0] offset;
  } dec_fields_t;
endpackage

// File: rtl/ras_ret_decode.sv
module ras_ret_decode
  import ras_pkg::*;
#(
  parameter int unsigned PC_IDX  = 15,
  parameter int unsigned SP_IDX  = 13,
  parameter int unsigned RET_OFF = 4
) (
  input  dec_fields_t fields_i,
  output logic        is_ret_o
);
  localparam logic [REG_W-1:0] PcIdx  = REG_W'(PC_IDX);
  localparam logic [REG_W-1:0] SpIdx  = REG_W'(SP_IDX);
  localparam logic [OFF_W-1:0] RetOff = OFF_W'(RET_OFF);

  logic reg_match, mode_match;

  always_comb begin
    reg_match  = (fields_i.rd == PcIdx) && (fields_i.rn == SpIdx);
    mode_match = fields_i.post_idx && fields_i.imm && fields_i.up &&
                 (fields_i.offset == RetOff);
    is_ret_o   = fields_i.valid && fields_i.single_load && reg_match && mode_match;
  end
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_req_i,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_ptr_i,
  input  logic [CW-1:0] flush_cnt_i,
  output logic          pop_fire_o,
  output logic [AW-1:0] wr_idx_o,
  output logic [AW-1:0] rd_idx_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [AW-1:0] LastIdx = AW'(DEPTH - 1);
  localparam logic [CW-1:0] MaxCnt  = CW'(DEPTH);

  logic [AW-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec, flush_ptr_c;
  logic [CW-1:0] cnt_q, cnt_d, flush_cnt_c;
  logic          do_push;

  always_comb begin
    ptr_inc     = (ptr_q == LastIdx) ? '0 : ptr_q + AW'(1);
    ptr_dec     = (ptr_q == '0) ? LastIdx : ptr_q - AW'(1);
    flush_ptr_c = (flush_ptr_i > LastIdx) ? '0 : flush_ptr_i;
    flush_cnt_c = (flush_cnt_i > MaxCnt) ? MaxCnt : flush_cnt_i;
    do_push     = push_i && !flush_i;
    pop_fire_o  = pop_req_i && !push_i && !flush_i && (cnt_q != '0);
    ptr_d       = ptr_q;
    cnt_d       = cnt_q;
    if (flush_i) begin
      ptr_d = flush_ptr_c;
      cnt_d = flush_cnt_c;
    end else if (do_push) begin
      ptr_d = ptr_inc;
      cnt_d = (cnt_q == MaxCnt) ? MaxCnt : cnt_q + CW'(1);
    end else if (pop_fire_o) begin
      ptr_d = ptr_dec;
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_idx_o = ptr_q;
  assign rd_idx_o = ptr_dec;
  assign cnt_o    = cnt_q;

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MaxCnt);

  assert_flush_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && flush_cnt_i <= MaxCnt && flush_ptr_i <= LastIdx) |=>
      (ptr_q == $past(flush_ptr_i) && cnt_q == $past(flush_cnt_i)));

  assert_empty_pop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && !push_i && !flush_i && cnt_q == '0) |=>
      (cnt_q == '0 && $stable(ptr_q)));

  assert_push_grows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i && cnt_q != MaxCnt) |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[g] <= '0;
      end else if (we_i && waddr_i == AW'(g)) begin
        entry_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = entry_q[raddr_i];

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> entry_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
  import ras_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              dec_valid_i,
  input  logic              dec_single_load_i,
  input  logic [REG_W-1:0]  dec_rd_i,
  input  logic [REG_W-1:0]  dec_rn_i,
  input  logic              dec_post_idx_i,
  input  logic              dec_imm_i,
  input  logic              dec_up_i,
  input  logic [OFF_W-1:0]  dec_offset_i,
  input  logic [3:0]        dec_cond_i,
  input  logic              flush_i,
  input  logic [AW-1:0]     flush_ptr_i,
  input  logic [CW-1:0]     flush_cnt_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic [AW-1:0]     ckpt_ptr_o,
  output logic [CW-1:0]     ckpt_cnt_o
);
  dec_fields_t       fields;
  logic              ret_hit, pop_fire;
  logic [AW-1:0]     wr_idx, rd_idx;
  logic [ADDR_W-1:0] rd_data;
  logic              pred_valid_q;
  logic [ADDR_W-1:0] pred_target_q;
  logic              cond_unused;

  assign cond_unused = ^dec_cond_i;  // condition outcome is resolved elsewhere

  always_comb begin
    fields.valid       = dec_valid_i;
    fields.single_load = dec_single_load_i;
    fields.rd          = dec_rd_i;
    fields.rn          = dec_rn_i;
    fields.post_idx    = dec_post_idx_i;
    fields.imm         = dec_imm_i;
    fields.up          = dec_up_i;
    fields.offset      = dec_offset_i;
  end

  ras_ret_decode i_ret_decode (
    .fields_i (fields),
    .is_ret_o (ret_hit)
  );

  ras_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_req_i   (ret_hit),
    .flush_i     (flush_i),
    .flush_ptr_i (flush_ptr_i),
    .flush_cnt_i (flush_cnt_i),
    .pop_fire_o  (pop_fire),
    .wr_idx_o    (wr_idx),
    .rd_idx_o    (rd_idx),
    .cnt_o       (ckpt_cnt_o)
  );

  ras_store #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push_i && !flush_i),
    .waddr_i (wr_idx),
    .wdata_i (push_addr_i),
    .raddr_i (rd_idx),
    .rdata_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_q  <= 1'b0;
      pred_target_q <= '0;
    end else begin
      pred_valid_q <= pop_fire;
      if (pop_fire) pred_target_q <= {rd_data[ADDR_W-1:1], 1'b0};
    end
  end

  assign pred_valid_o  = pred_valid_q;
  assign pred_target_o = pred_target_q;
  assign ckpt_ptr_o    = wr_idx;

  assert_pred_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> $past(ret_hit));

  assert_push_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> !pred_valid_o);

  assert_flush_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pred_valid_o);

  assert_target_even_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> !pred_target_o[0]);
endmodule

// File: tb/test_ras_predictor.sv
module test_ras_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [31:0] push_addr_i = '0;
  logic        dec_valid_i = 1'b0, dec_single_load_i = 1'b0;
  logic [3:0]  dec_rd_i = '0, dec_rn_i = '0;
  logic        dec_post_idx_i = 1'b0, dec_imm_i = 1'b0, dec_up_i = 1'b0;
  logic [11:0] dec_offset_i = '0;
  logic [3:0]  dec_cond_i = 4'hE;
  logic        flush_i = 1'b0;
  logic [1:0]  flush_ptr_i = '0;
  logic [2:0]  flush_cnt_i = '0;
  logic        pred_valid_o;
  logic [31:0] pred_target_o;
  logic [1:0]  ckpt_ptr_o;
  logic [2:0]  ckpt_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ras_predictor i_ras_predictor (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    push_i = 1'b0; dec_valid_i = 1'b0; dec_single_load_i = 1'b0;
    dec_rd_i = '0; dec_rn_i = '0; dec_post_idx_i = 1'b0; dec_imm_i = 1'b0;
    dec_up_i = 1'b0; dec_offset_i = '0; dec_cond_i = 4'hE; flush_i = 1'b0;
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic set_ret();
    dec_valid_i = 1'b1; dec_single_load_i = 1'b1; dec_rd_i = 4'd15;
    dec_rn_i = 4'd13; dec_post_idx_i = 1'b1; dec_imm_i = 1'b1;
    dec_up_i = 1'b1; dec_offset_i = 12'd4;
  endtask

  task automatic push(logic [31:0] a);
    idle(); push_i = 1'b1; push_addr_i = a; step(); idle();
  endtask

  task automatic ret_expect(string req, bit v, logic [31:0] t);
    idle(); set_ret(); step(); idle();
    check(req, 32'(pred_valid_o), 32'(v));
    if (v) check(req, pred_target_o, t);
  endtask

  task automatic restore(logic [1:0] p, logic [2:0] c);
    idle(); flush_i = 1'b1; flush_ptr_i = p; flush_cnt_i = c; step(); idle();
  endtask

  task automatic t_reset();
    check("R1", 32'(pred_valid_o), 0);
    check("R1", 32'(ckpt_ptr_o), 0);
    check("R1", 32'(ckpt_cnt_o), 0);
  endtask

  task automatic t_lifo();
    push(32'h1000_0004); push(32'h2000_0008); push(32'h3000_000C);
    check("R10", 32'(ckpt_cnt_o), 3);
    check("R10", 32'(ckpt_ptr_o), 3);
    ret_expect("R3", 1, 32'h3000_000C);
    ret_expect("R3", 1, 32'h2000_0008);
    ret_expect("R3", 1, 32'h1000_0004);
    check("R3", 32'(ckpt_cnt_o), 0);
  endtask

  task automatic t_decode();
    restore(2'd0, 3'd0);
    push(32'h4444_0000);
    for (int k = 0; k < 9; k++) begin
      idle(); set_ret();
      case (k)
        0: dec_valid_i = 1'b0;
        1: dec_single_load_i = 1'b0;
        2: dec_rd_i = 4'd14;
        3: dec_rn_i = 4'd12;
        4: dec_post_idx_i = 1'b0;
        5: dec_imm_i = 1'b0;
        6: dec_up_i = 1'b0;
        7: dec_offset_i = 12'd8;
        default: dec_offset_i = 12'd0;
      endcase
      step(); idle();
      check("R2", 32'(pred_valid_o), 0);
      check("R2", 32'(ckpt_cnt_o), 1);
    end
    ret_expect("R2", 1, 32'h4444_0000);
  endtask

  task automatic t_cond();
    push(32'h5000_0010);
    idle(); set_ret(); dec_cond_i = 4'h0; step(); idle();
    check("R9", 32'(pred_valid_o), 1);
    check("R9", pred_target_o, 32'h5000_0010);
    push(32'h5000_0020);
    idle(); set_ret(); dec_cond_i = 4'hB; step(); idle();
    check("R9", 32'(pred_valid_o), 1);
    check("R9", pred_target_o, 32'h5000_0020);
  endtask

  task automatic t_empty();
    logic [1:0] p0;
    p0 = ckpt_ptr_o;
    check("R5", 32'(ckpt_cnt_o), 0);
    ret_expect("R5", 0, '0);
    check("R5", 32'(ckpt_cnt_o), 0);
    check("R5", 32'(ckpt_ptr_o), 32'(p0));
  endtask

  task automatic t_overflow();
    restore(2'd0, 3'd0);
    for (int i = 1; i <= 5; i++) push(32'hA000_0000 + 32'(i * 16));
    check("R10", 32'(ckpt_cnt_o), 4);
    check("R10", 32'(ckpt_ptr_o), 1);
    for (int i = 5; i >= 2; i--) ret_expect("R4", 1, 32'hA000_0000 + 32'(i * 16));
    ret_expect("R4", 0, '0);
  endtask

  task automatic t_bit0();
    push(32'h0000_1235);
    ret_expect("R8", 1, 32'h0000_1234);
  endtask

  task automatic t_same_cycle();
    restore(2'd0, 3'd0);
    push(32'hB000_0100);
    idle(); set_ret(); push_i = 1'b1; push_addr_i = 32'hB000_0200; step(); idle();
    check("R6", 32'(pred_valid_o), 0);
    check("R6", 32'(ckpt_cnt_o), 2);
    ret_expect("R6", 1, 32'hB000_0200);
    ret_expect("R6", 1, 32'hB000_0100);
  endtask

  task automatic t_flush();
    restore(2'd0, 3'd0);
    push(32'hC000_0A00); push(32'hC000_0B00); push(32'hC000_0C00);
    ret_expect("R7", 1, 32'hC000_0C00);
    push(32'hC000_0D00); push(32'hC000_0E00);
    check("R7", 32'(ckpt_cnt_o), 4);
    idle(); set_ret(); push_i = 1'b1; push_addr_i = 32'hC000_0F00;
    flush_i = 1'b1; flush_ptr_i = 2'd3; flush_cnt_i = 3'd3; step(); idle();
    check("R7", 32'(pred_valid_o), 0);
    check("R7", 32'(ckpt_ptr_o), 3);
    check("R7", 32'(ckpt_cnt_o), 3);
    ret_expect("R7", 1, 32'hC000_0D00);
    ret_expect("R7", 1, 32'hC000_0B00);
    ret_expect("R7", 1, 32'hC000_0A00);
    ret_expect("R7", 0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_lifo();
    t_decode();
    t_cond();
    t_empty();
    t_overflow();
    t_bit0();
    t_same_cycle();
    t_flush();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule